// File: doc/BRIEF.md
# Memory ECC Error Capture Registers

This block records diagnostic state for the latest reported error on a RAM bus that is protected by error correcting code. An external checker raises one of two event strobes: one for a single-bit error that was corrected, one for a multi-bit error that could not be corrected. Each kind of event has its own enable bit in a configuration register. When an event arrives and its enable bit is set, the block stores four things: the faulting address, an attribute word holding the access size and protection codes, the syndrome, and the data word. It also sets the status flag that matches the event.

Software reaches the block through a simple word-wide register port. The read is combinational and the write takes effect at the clock edge. Software reads the captured values, clears status flags by writing ones to them, and sets the enables. The capture registers are read-only. Each enabled event overwrites the previous capture, so the registers always describe the most recent one.

Top module: `ecc_err_capture`

## Requirements
- R1: In the cycle after an event strobe whose enable bit is set, the address register (offset 0x60) holds that event's address and the syndrome register (offset 0x68) holds its syndrome, zero-extended.
- R2: An enabled corrected event sets status bit 0 (offset 0x44). An enabled uncorrectable event sets status bit 1. When both kinds are enabled and strobe in the same cycle, both bits are set.
- R3: The configuration register (offset 0x40) is read/write. Bit 0 enables capture of corrected events and bit 1 enables capture of uncorrectable events. An event whose enable bit is clear changes no capture register and no flag.
- R4: The attribute register (offset 0x64) holds the size code in bits 2:0 (000 = 8-bit, 001 = 16-bit, 010 = 32-bit, 1xx reserved) and the protection code in bits 7:4. Bit 7 is cacheable, bit 6 is bufferable, bit 5 is supervisor (1) or user (0), and bit 4 is data (1) or instruction fetch (0). All other bits read zero.
- R5: The data register at offset 0x6C is 32 bits wide and holds the data word of the last enabled event. After an uncorrectable event its value is undefined.
- R6: The address, attribute, syndrome and data registers ignore writes.
- R7: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R8: If an enabled event and a clear of its flag occur in the same cycle, the flag stays set.
- R9: A later enabled event overwrites every capture register from an earlier event.
- R10: Reads of unmapped offsets return zero, and writes to them change no register.
- R11: After reset, the configuration, status, address, attribute and syndrome registers read zero. The reset value of the data register is undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_sbc_i | input | 1 | Strobe for a corrected single-bit event |
| ev_mbe_i | input | 1 | Strobe for an uncorrectable multi-bit event |
| ev_addr_i | input | ADDR_W | Address of the faulting access |
| ev_size_i | input | 3 | Size code of the faulting access |
| ev_prot_i | input | 4 | Protection code of the faulting access |
| ev_synd_i | input | SYND_W | Syndrome from the checker |
| ev_data_i | input | DATA_W | Data word of the faulting access |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | OFS_W | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |

## Verification
The bench targets four corner cases.

- A flag clear that lands in the same cycle as a new event for that flag must leave the flag set. A design that let the clear win would lose an error report.
- Events that strobe while their enable bit is clear must change nothing. A design that decoded the enable wrongly, or captured unconditionally, would overwrite the address of the last real event.
- Writes to the read-only capture offsets must have no effect. So must writes of zero to the status register and writes to unmapped offsets. A decoder that is too permissive would corrupt the captured state or read back garbage where zero is expected.
- On every cycle, a randomized stream of mixed events and register traffic is compared with a behavioural model. The data word is not compared after uncorrectable events.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int unsigned OFS_W = 8;

  localparam logic [OFS_W-1:0] OFS_CFG  = 8'h40;
  localparam logic [OFS_W-1:0] OFS_STAT = 8'h44;
  localparam logic [OFS_W-1:0] OFS_ADDR = 8'h60;
  localparam logic [OFS_W-1:0] OFS_ATTR = 8'h64;
  localparam logic [OFS_W-1:0] OFS_SYND = 8'h68;
  localparam logic [OFS_W-1:0] OFS_DATA = 8'h6C;

  localparam int unsigned N_FLAG   = 2;
  localparam int unsigned FLAG_SBC = 0;
  localparam int unsigned FLAG_MBE = 1;

  typedef struct packed {
    logic [3:0] prot;
    logic [2:0] size;
  } attr_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CFG,
    SEL_STAT,
    SEL_ADDR,
    SEL_ATTR,
    SEL_SYND,
    SEL_DATA
  } sel_e;

  function automatic sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
    unique case (ofs)
      OFS_CFG:  return SEL_CFG;
      OFS_STAT: return SEL_STAT;
      OFS_ADDR: return SEL_ADDR;
      OFS_ATTR: return SEL_ATTR;
      OFS_SYND: return SEL_SYND;
      OFS_DATA: return SEL_DATA;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl
  import ecc_cap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_sbc_i,
  input  logic              ev_mbe_i,
  input  logic              wr_cfg_i,
  input  logic              wr_stat_i,
  input  logic [N_FLAG-1:0] wbits_i,
  output logic [N_FLAG-1:0] cfg_o,
  output logic [N_FLAG-1:0] stat_o,
  output logic [N_FLAG-1:0] fire_o
);
  logic [N_FLAG-1:0] cfg_q, stat_q, stat_d, ev_vec, clr_vec;

  assign ev_vec  = {ev_mbe_i, ev_sbc_i};
  assign fire_o  = ev_vec & cfg_q;
  assign clr_vec = wr_stat_i ? wbits_i : '0;
  // a set in the same cycle outranks a clear
  assign stat_d  = (stat_q & ~clr_vec) | fire_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      stat_q <= '0;
    end else begin
      if (wr_cfg_i) cfg_q <= wbits_i;
      stat_q <= stat_d;
    end
  end

  assign cfg_o  = cfg_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/ecc_cap_store.sv
module ecc_cap_store
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SYND_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter bit          DATA_RST = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  attr_t             attr_i,
  input  logic [SYND_W-1:0] synd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output attr_t             attr_o,
  output logic [SYND_W-1:0] synd_o,
  output logic [DATA_W-1:0] data_o
);
  logic [ADDR_W-1:0] addr_q;
  attr_t             attr_q;
  logic [SYND_W-1:0] synd_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      attr_q <= '0;
      synd_q <= '0;
    end else if (capture_i) begin
      addr_q <= addr_i;
      attr_q <= attr_i;
      synd_q <= synd_i;
    end
  end

  generate
    if (DATA_RST) begin : g_data_rst
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        data_q <= '0;
        else if (capture_i) data_q <= data_i;
      end
    end else begin : g_data_nrst
      logic unused_rst;
      assign unused_rst = rst_ni;
      always_ff @(posedge clk_i) begin
        if (capture_i) data_q <= data_i;
      end
    end
  endgenerate

  assign addr_o = addr_q;
  assign attr_o = attr_q;
  assign synd_o = synd_q;
  assign data_o = data_q;
endmodule

// File: rtl/ecc_cap_rdmux.sv
module ecc_cap_rdmux
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SYND_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  sel_e              sel_i,
  input  logic [N_FLAG-1:0] cfg_i,
  input  logic [N_FLAG-1:0] stat_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  attr_t             attr_i,
  input  logic [SYND_W-1:0] synd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [31:0]       rdata_o
);
  logic [31:0] attr_word;

  always_comb begin
    attr_word      = '0;
    attr_word[2:0] = attr_i.size;
    attr_word[7:4] = attr_i.prot;
  end

  always_comb begin
    unique case (sel_i)
      SEL_CFG:  rdata_o = 32'(cfg_i);
      SEL_STAT: rdata_o = 32'(stat_i);
      SEL_ADDR: rdata_o = 32'(addr_i);
      SEL_ATTR: rdata_o = attr_word;
      SEL_SYND: rdata_o = 32'(synd_i);
      SEL_DATA: rdata_o = 32'(data_i);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SYND_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter bit          DATA_RST = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_sbc_i,
  input  logic              ev_mbe_i,
  input  logic [ADDR_W-1:0] ev_addr_i,
  input  logic [2:0]        ev_size_i,
  input  logic [3:0]        ev_prot_i,
  input  logic [SYND_W-1:0] ev_synd_i,
  input  logic [DATA_W-1:0] ev_data_i,
  input  logic              reg_we_i,
  input  logic [OFS_W-1:0]  reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o
);
  sel_e              sel;
  logic              wr_cfg, wr_stat, capture;
  logic [N_FLAG-1:0] cfg_q, stat_q, fire;
  logic [ADDR_W-1:0] addr_q;
  attr_t             attr_q, attr_in;
  logic [SYND_W-1:0] synd_q;
  logic [DATA_W-1:0] data_q;
  logic              unused_wdata;

  assign sel          = decode_ofs(reg_addr_i);
  assign wr_cfg       = reg_we_i && (sel == SEL_CFG);
  assign wr_stat      = reg_we_i && (sel == SEL_STAT);
  assign capture      = |fire;
  assign attr_in      = '{prot: ev_prot_i, size: ev_size_i};
  assign unused_wdata = ^reg_wdata_i[31:N_FLAG];

  ecc_cap_ctrl i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_sbc_i (ev_sbc_i),
    .ev_mbe_i (ev_mbe_i),
    .wr_cfg_i (wr_cfg),
    .wr_stat_i(wr_stat),
    .wbits_i  (reg_wdata_i[N_FLAG-1:0]),
    .cfg_o    (cfg_q),
    .stat_o   (stat_q),
    .fire_o   (fire)
  );

  ecc_cap_store #(
    .ADDR_W  (ADDR_W),
    .SYND_W  (SYND_W),
    .DATA_W  (DATA_W),
    .DATA_RST(DATA_RST)
  ) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .addr_i   (ev_addr_i),
    .attr_i   (attr_in),
    .synd_i   (ev_synd_i),
    .data_i   (ev_data_i),
    .addr_o   (addr_q),
    .attr_o   (attr_q),
    .synd_o   (synd_q),
    .data_o   (data_q)
  );

  ecc_cap_rdmux #(
    .ADDR_W(ADDR_W),
    .SYND_W(SYND_W),
    .DATA_W(DATA_W)
  ) i_rdmux (
    .sel_i  (sel),
    .cfg_i  (cfg_q),
    .stat_i (stat_q),
    .addr_i (addr_q),
    .attr_i (attr_q),
    .synd_i (synd_q),
    .data_i (data_q),
    .rdata_o(reg_rdata_o)
  );
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_FLAG-1:0] fire,
  input logic [ADDR_W-1:0] ev_addr_i,
  input logic [ADDR_W-1:0] addr_q,
  input logic [N_FLAG-1:0] stat_q,
  input logic [DATA_W-1:0] data_q,
  input logic              reg_we_i,
  input logic [OFS_W-1:0]  reg_addr_i,
  input logic [N_FLAG-1:0] wbits,
  input logic [31:0]       reg_rdata_o
);
  logic mapped, clr_sbc;
  assign mapped  = (reg_addr_i == OFS_CFG)  || (reg_addr_i == OFS_STAT) ||
                   (reg_addr_i == OFS_ADDR) || (reg_addr_i == OFS_ATTR) ||
                   (reg_addr_i == OFS_SYND) || (reg_addr_i == OFS_DATA);
  assign clr_sbc = reg_we_i && (reg_addr_i == OFS_STAT) && wbits[0];

  p_addr_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fire) |=> addr_q == $past(ev_addr_i));
  p_sbc_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire[0] |=> stat_q[0]);
  p_mbe_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire[1] |=> stat_q[1]);
  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|fire) |=> $stable(addr_q));
  p_data_ro_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_DATA && !(|fire)) |=> $stable(data_q));
  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[0] && !clr_sbc) |=> stat_q[0]);
  p_event_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire[0] && clr_sbc) |=> stat_q[0]);
  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> reg_rdata_o == 32'd0);
endmodule

bind ecc_err_capture ecc_err_capture_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fire       (fire),
  .ev_addr_i  (ev_addr_i),
  .addr_q     (addr_q),
  .stat_q     (stat_q),
  .data_q     (data_q),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .wbits      (reg_wdata_i[1:0]),
  .reg_rdata_o(reg_rdata_o)
);

// File: tb/test_ecc_err_capture.sv
`timescale 1ns/1ps
module test_ecc_err_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_sbc = 1'b0, ev_mbe = 1'b0;
  logic [31:0] ev_addr = '0;
  logic [2:0]  ev_size = '0;
  logic [3:0]  ev_prot = '0;
  logic [7:0]  ev_synd = '0;
  logic [31:0] ev_data = '0;
  logic        we = 1'b0;
  logic [7:0]  raddr = 8'h40;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model state
  logic [1:0]  m_cfg, m_stat;
  logic [31:0] m_addr, m_data;
  logic [7:0]  m_attr, m_synd;
  bit          m_data_ok;

  always #2.5 clk = ~clk;

  ecc_err_capture i_ecc_err_capture (
    .clk_i(clk), .rst_ni(rst_n), .ev_sbc_i(ev_sbc), .ev_mbe_i(ev_mbe),
    .ev_addr_i(ev_addr), .ev_size_i(ev_size), .ev_prot_i(ev_prot),
    .ev_synd_i(ev_synd), .ev_data_i(ev_data), .reg_we_i(we),
    .reg_addr_i(raddr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_rd(input logic [7:0] a, output logic [31:0] v,
                                   output bit ok, output string tag);
    ok = 1'b1; v = '0; tag = "R10";
    case (a)
      8'h40: begin v = 32'(m_cfg);  tag = "R3"; end
      8'h44: begin v = 32'(m_stat); tag = "R2"; end
      8'h60: begin v = m_addr;      tag = "R1"; end
      8'h64: begin v = 32'(m_attr); tag = "R4"; end
      8'h68: begin v = 32'(m_synd); tag = "R1"; end
      8'h6C: begin v = m_data; ok = m_data_ok; tag = "R5"; end
      default: ;
    endcase
  endfunction

  // model updates at the edge, compares 1 ns later on every clock
  always @(posedge clk) begin
    logic [31:0] ev; bit ok; string tg;
    if (!rst_n) begin
      m_cfg = 0; m_stat = 0; m_addr = 0; m_attr = 0; m_synd = 0; m_data_ok = 0;
    end else begin
      logic fs, fm; logic [1:0] clr;
      fs  = ev_sbc && m_cfg[0];
      fm  = ev_mbe && m_cfg[1];
      clr = (we && raddr == 8'h44) ? wdata[1:0] : 2'b00;
      m_stat = (m_stat & ~clr) | {fm, fs};
      if (fs || fm) begin
        m_addr = ev_addr; m_attr = {ev_prot, 1'b0, ev_size};
        m_synd = ev_synd; m_data = ev_data; m_data_ok = !fm;
      end
      if (we && raddr == 8'h40) m_cfg = wdata[1:0];
    end
    #1;
    if (rst_n) begin
      model_rd(raddr, ev, ok, tg);
      if (ok) chk(tg, rdata, ev);
    end
  end

  task automatic drive(input logic s, input logic m, input logic w,
                       input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    ev_sbc = s; ev_mbe = m; we = w; raddr = a; wdata = d;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    ev_sbc = 0; ev_mbe = 0; we = 0; raddr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic set_ev(input logic [31:0] a, input logic [2:0] sz, input logic [3:0] pr,
                        input logic [7:0] sy, input logic [31:0] d);
    ev_addr = a; ev_size = sz; ev_prot = pr; ev_synd = sy; ev_data = d;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    rd(8'h40, 0, "R11"); rd(8'h44, 0, "R11"); rd(8'h60, 0, "R11");
    rd(8'h64, 0, "R11"); rd(8'h68, 0, "R11");
    // R3 enable both
    drive(0, 0, 1, 8'h40, 32'h3);
    rd(8'h40, 32'h3, "R3");
    // R1 R2 R4 R5 corrected event
    set_ev(32'h1000_0ABC, 3'b010, 4'b1011, 8'h5A, 32'hDEAD_BEEF);
    drive(1, 0, 0, 8'h44, 0);
    rd(8'h60, 32'h1000_0ABC, "R1"); rd(8'h68, 32'h5A, "R1");
    rd(8'h64, 32'hB2, "R4"); rd(8'h6C, 32'hDEAD_BEEF, "R5"); rd(8'h44, 32'h1, "R2");
    // R6 writes to capture registers ignored
    drive(0, 0, 1, 8'h6C, 32'h1234_5678); drive(0, 0, 1, 8'h60, 32'hFFFF_FFFF);
    drive(0, 0, 1, 8'h64, 32'hFF);        drive(0, 0, 1, 8'h68, 32'hFF);
    rd(8'h6C, 32'hDEAD_BEEF, "R6"); rd(8'h60, 32'h1000_0ABC, "R6");
    rd(8'h64, 32'hB2, "R6"); rd(8'h68, 32'h5A, "R6");
    // R7 write-one-to-clear
    drive(0, 0, 1, 8'h44, 32'h0); rd(8'h44, 32'h1, "R7");
    drive(0, 0, 1, 8'h44, 32'h1); rd(8'h44, 32'h0, "R7");
    // R2 uncorrectable event
    set_ev(32'h2000_0004, 3'b000, 4'b0001, 8'hC3, 32'h0);
    drive(0, 1, 0, 8'h44, 0);
    rd(8'h44, 32'h2, "R2"); rd(8'h60, 32'h2000_0004, "R1"); rd(8'h64, 32'h10, "R4");
    // R3 disabled events ignored
    drive(0, 0, 1, 8'h40, 32'h0);
    set_ev(32'h3333_3330, 3'b001, 4'hF, 8'h11, 32'h5555_5555);
    drive(1, 1, 0, 8'h44, 0);
    rd(8'h44, 32'h2, "R3"); rd(8'h60, 32'h2000_0004, "R3"); rd(8'h68, 32'hC3, "R3");
    drive(0, 0, 1, 8'h40, 32'h1);
    drive(0, 1, 0, 8'h44, 0);
    rd(8'h60, 32'h2000_0004, "R3");
    // R9 overwrite by later event
    set_ev(32'h4444_0000, 3'b001, 4'b0110, 8'h7E, 32'h0BAD_F00D);
    drive(1, 0, 0, 8'h44, 0);
    rd(8'h60, 32'h4444_0000, "R9"); rd(8'h64, 32'h61, "R9");
    rd(8'h6C, 32'h0BAD_F00D, "R9"); rd(8'h44, 32'h3, "R2");
    // R8 event beats a simultaneous clear
    drive(1, 0, 1, 8'h44, 32'h3);
    rd(8'h44, 32'h1, "R8");
    // R10 unmapped offsets
    drive(0, 0, 1, 8'h50, 32'hFFFF_FFFF);
    rd(8'h50, 32'h0, "R10"); rd(8'h7C, 32'h0, "R10"); rd(8'h40, 32'h1, "R10");
    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [7:0] ofs;
      case ($urandom_range(0, 8))
        0: ofs = 8'h40; 1: ofs = 8'h44; 2: ofs = 8'h60; 3: ofs = 8'h64;
        4: ofs = 8'h68; 5: ofs = 8'h6C; 6: ofs = 8'h50; 7: ofs = 8'h00;
        default: ofs = 8'h44;
      endcase
      set_ev($urandom, 3'($urandom_range(0, 2)), 4'($urandom), 8'($urandom), $urandom);
      drive(($urandom_range(0, 4) == 0), ($urandom_range(0, 5) == 0),
            ($urandom_range(0, 3) == 0), ofs, 32'($urandom_range(0, 3)));
    end
    drive(0, 0, 0, 8'h40, 0);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule